// File: doc/BRIEF.md
# Crossbar sneak-path event detector

This block decides, for every cell of a small square binary memory array, whether reading that cell would be disturbed by a three-cell sneak path. Two maps are loaded into it through a row-wide write port. The first holds the stored bits. The second marks the cells whose series selector has failed. A pulse on `start` launches a scan that examines one target cell per clock in row-major order. When the scan ends, `done` rises. A per-cell indicator map can then be read back one row at a time, and a counter gives the number of affected cells, which is the numerator of the array's sneak-path rate.

A target cell holding 0 is affected when some other row k and some other column l give a rectangle in which the same-row cell, the same-column cell and the diagonal cell all hold 1, and the selector of that diagonal cell is marked failed. The selectors of the same-row and same-column cells play no part, because current passes through those two cells in the forward direction. The failure map does not change during a scan.

Top module: `sneak_scan`

## Requirements
- R1: A cell that stores 1 is never flagged, whatever the contents of the failure map.
- R2: A cell (i,j) that stores 0 is flagged exactly when there is a row k≠i and a column l≠j such that cells (i,l), (k,j) and (k,l) all store 1 and the failure map marks (k,l). The cell is flagged if any such (k,l) exists.
- R3: The failure marks of the same-row cell (i,l) and the same-column cell (k,j) have no influence on the flag of (i,j). Only the mark of the diagonal cell counts.
- R4: `count` is cleared by an accepted start. When `done` is high, it equals the number of flagged cells.
- R5: An accepted start drives `busy` high on the next clock edge. The scan visits one cell per clock, so `done` rises on the N*N-th clock edge after the edge that accepted the start. `busy` and `done` are never high together, and `done` stays high until the next accepted start.
- R6: While `busy` is high, write-port accesses and further `start` pulses are ignored. They neither alter the maps nor restart or lengthen the scan.
- R7: A write with `wr_sel`=0 loads data-map row `wr_row`, and a write with `wr_sel`=1 loads the failure-map row. Bit l of `wr_data` is column l.
- R8: Bit j of `rd_data` is the flag of cell (`rd_row`, j). Flags are cleared by an accepted start and hold their values after `done` until the next accepted start.
- R9: After reset, `busy`, `done`, `count`, every flag and both maps are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Row write strobe |
| wr_sel | input | 1 | 0 selects the data map, 1 selects the failure map |
| wr_row | input | $clog2(N) | Row address of the write |
| wr_data | input | N | Row contents; bit l is column l |
| start | input | 1 | Scan start pulse, accepted only when not busy |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished; result valid |
| count | output | $clog2(N*N+1) | Number of flagged cells |
| rd_row | input | $clog2(N) | Row address of the flag read |
| rd_data | output | N | Flags of row `rd_row`; bit j is column j |

## Verification
The hardest situation to reach is one that separates the diagonal selector from the other two selectors on the path. A single hand-built rectangle is therefore loaded three times. First the failure mark sits on the diagonal cell. Then it moves to the same-row cell, and then to the same-column cell. Only the first arrangement may flag the target. A second case that is hard to reach from the ports is a write or a start arriving in the middle of a scan. The bench injects both while `busy` is high. It then checks that the scan still ends on the 16th edge, and that a fresh scan of the untouched maps gives the original result.

// File: rtl/sneak_scan.sv
module sneak_scan #(
  parameter int N = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_sel,
  input  logic [$clog2(N)-1:0]         wr_row,
  input  logic [N-1:0]                 wr_data,
  input  logic                         start,
  output logic                         busy,
  output logic                         done,
  output logic [$clog2(N*N+1)-1:0]     count,
  input  logic [$clog2(N)-1:0]         rd_row,
  output logic [N-1:0]                 rd_data
);
  localparam int RW = $clog2(N);
  localparam int CW = $clog2(N*N+1);

  logic [N-1:0]  dmap [N];
  logic [N-1:0]  fmap [N];
  logic [N-1:0]  flg  [N];
  logic [RW-1:0] ri, ci;
  logic [N-1:0]  rowm;
  logic          hit;
  logic          go, last;

  assign go      = start && !busy;
  assign last    = (ri == RW'(N-1)) && (ci == RW'(N-1));
  assign rd_data = flg[rd_row];

  always_comb begin
    rowm     = dmap[ri];
    rowm[ci] = 1'b0;
    hit      = 1'b0;
    for (int k = 0; k < N; k++)
      if (RW'(k) != ri && dmap[k][ci] && |(dmap[k] & fmap[k] & rowm))
        hit = 1'b1;
    hit = hit & ~dmap[ri][ci];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++) begin
        dmap[r] <= '0;
        fmap[r] <= '0;
      end
    end else if (wr_en && !busy) begin
      if (wr_sel) fmap[wr_row] <= wr_data;
      else        dmap[wr_row] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      count <= '0;
      ri    <= '0;
      ci    <= '0;
      for (int r = 0; r < N; r++) flg[r] <= '0;
    end else if (go) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      count <= '0;
      ri    <= '0;
      ci    <= '0;
      for (int r = 0; r < N; r++) flg[r] <= '0;
    end else if (busy) begin
      flg[ri][ci] <= hit;
      count       <= count + CW'(hit);
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (ci == RW'(N-1)) begin
        ci <= '0;
        ri <= ri + 1'b1;
      end else begin
        ci <= ci + 1'b1;
      end
    end
  end

  AST_ONE_NEVER_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dmap[ri][ci]) |=> (count == $past(count))) else $error("one counted"); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (busy && !done && count == '0)) else $error("start not clean"); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !go) |=> (count - $past(count) <= CW'(1))) else $error("count jump"); // R4
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)) else $error("busy and done"); // R5
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done) else $error("done dropped"); // R5
  AST_MAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(dmap[0]) && $stable(fmap[0]) && $stable(dmap[N-1]) && $stable(fmap[N-1])))
    else $error("map changed in scan"); // R6
endmodule

// File: tb/sneak_scan_tb.sv
module sneak_scan_tb_top;
  localparam int N  = 4;
  localparam int RW = $clog2(N);
  localparam int CW = $clog2(N*N+1);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0, start = 0;
  logic [RW-1:0] wr_row = '0, rd_row = '0;
  logic [N-1:0]  wr_data = '0, rd_data;
  logic busy, done;
  logic [CW-1:0] count;

  int checks = 0, fails = 0, wd = 0;

  always #5 clk = ~clk;

  sneak_scan #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_row(wr_row),
    .wr_data(wr_data), .start(start), .busy(busy), .done(done), .count(count),
    .rd_row(rd_row), .rd_data(rd_data));

  // data map, failure map; bit i*N+j is cell (i,j)
  localparam logic [31:0] VEC [8] = '{
    {16'h0000, 16'hFFFF}, {16'hFFFF, 16'hFFFF}, {16'h5A5A, 16'hFFFF},
    {16'hF0F0, 16'h0F0F}, {16'h8421, 16'hFFFF}, {16'h6C93, 16'hA5A5},
    {16'h7BDE, 16'h3C3C}, {16'hEEE0, 16'h1248}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic ref_flag(logic [15:0] d, logic [15:0] f, int i, int j);
    if (d[i*N+j]) return 1'b0;
    for (int k = 0; k < N; k++)
      for (int l = 0; l < N; l++)
        if (k != i && l != j && d[i*N+l] && d[k*N+j] && d[k*N+l] && f[k*N+l])
          return 1'b1;
    return 1'b0;
  endfunction

  task automatic load(logic [15:0] d, logic [15:0] f);
    for (int r = 0; r < N; r++) begin
      @(negedge clk); wr_en = 1; wr_sel = 0; wr_row = RW'(r); wr_data = d[r*N +: N];
      @(negedge clk); wr_sel = 1; wr_data = f[r*N +: N];
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic scan(output int cyc, input bit disturb);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    cyc = 1;
    if (busy && disturb) begin
      wr_en = 1; wr_sel = 0; wr_row = '0; wr_data = '1;
      @(negedge clk); cyc++; wr_sel = 1; start = 1;
      @(negedge clk); cyc++; wr_en = 0; start = 0;
    end
    while (!done && cyc < 1000) begin
      @(negedge clk); cyc++;
    end
    cyc = cyc - 1;
  endtask

  task automatic verify(string req, logic [15:0] d, logic [15:0] f);
    int exp_cnt = 0;
    for (int r = 0; r < N; r++) begin
      logic [N-1:0] er;
      for (int j = 0; j < N; j++) begin
        er[j] = ref_flag(d, f, r, j);
        exp_cnt += int'(er[j]);
      end
      rd_row = RW'(r); #1;
      chk({req, " R1 R2 R8 row flags"}, int'(rd_data), int'(er));
    end
    chk({req, " R4 count"}, int'(count), exp_cnt);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", wd, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [15:0] d, f;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy", int'(busy), 0);
    chk("R9 done", int'(done), 0);
    chk("R9 count", int'(count), 0);
    rd_row = '0; #1; chk("R9 flags", int'(rd_data), 0);
    rst_n = 1;
    @(negedge clk);
    scan(cyc, 0);
    chk("R9 empty maps count", int'(count), 0);

    // table of vectors, R7 load order
    foreach (VEC[v]) begin
      d = VEC[v][31:16]; f = VEC[v][15:0];
      load(d, f);
      scan(cyc, 0);
      chk("R5 scan length", cyc, N*N);
      chk("R5 busy low at done", int'(busy), 0);
      verify("table", d, f);
    end

    // R2 hand case: (0,1),(1,0),(1,1)=1, fail at diagonal (1,1) -> only (0,0) flagged
    load(16'h0032, 16'h0020);
    scan(cyc, 0);
    rd_row = 0; #1; chk("R2 hand row0", int'(rd_data), 1);
    rd_row = 1; #1; chk("R2 hand row1", int'(rd_data), 0);
    chk("R2 hand count", int'(count), 1);

    // R3 fail only at same-row cell (0,1) then same-column cell (1,0)
    load(16'h0032, 16'h0002);
    scan(cyc, 0);
    chk("R3 row selector count", int'(count), 0);
    load(16'h0032, 16'h0010);
    scan(cyc, 0);
    chk("R3 column selector count", int'(count), 0);

    // R1 all ones with every selector failed
    load(16'hFFFF, 16'hFFFF);
    scan(cyc, 0);
    chk("R1 all ones count", int'(count), 0);

    // R6 writes and start during busy are ignored
    d = 16'h6C93; f = 16'hA5A5;
    load(d, f);
    scan(cyc, 1);
    chk("R6 scan not restarted", cyc, N*N);
    verify("R6 disturbed", d, f);
    scan(cyc, 0);
    verify("R6 maps untouched", d, f);

    // R8 flags hold after done
    repeat (5) @(negedge clk);
    chk("R8 done held", int'(done), 1);
    verify("R8 hold", d, f);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule